// File: doc/BRIEF.md
# Six-Voice Sound Register Front End

This block is the register side of a six-voice wavetable sound generator. A processor writes bytes to ten small register offsets. The block keeps every control value that the sample engine will later use: one voice-select latch, the left and right master volumes, and a full set of settings for each voice. Each voice holds a pitch divider, a level, an enable, a direct-output mode, a panning byte, noise controls, a 32-entry wave table with its write pointer, and a direct sample.

All per-voice writes go to the voice named by the select latch. A write at the wave offset does one of two things, chosen by the voice's direct-output bit. With the bit clear, the sample goes into the table at the write pointer and the pointer moves on. With the bit set, the sample becomes the voice's direct output value instead.

Each write is decoded into one write kind: select, master volume, pitch low, pitch high, control, pan, wave, noise, modulation rate or modulation control. Any other offset decodes to no kind. The decoded kind steers a single clocked update.

The read ports are combinational. Any voice and any table entry can be inspected without disturbing the stored state.

Top module: `snd_regfront`

## Requirements
- R1: A write at offset 0 loads the voice-select latch from data bits 2:0. Bits 7:3 are ignored.
- R2: A write at offset 1 sets the left master volume from data bits 7:4 and the right master volume from bits 3:0.
- R3: Offset 2 replaces bits 7:0 of the selected voice's 12-bit pitch. Offset 3 replaces bits 11:8 with data bits 3:0, and data bits 7:4 are dropped.
- R4: Offset 4 sets the voice level from bits 4:0, the enable from bit 7 and the direct mode from bit 6. When bit 7 is 0 and bit 6 is 1, the wave write pointer returns to 0.
- R5: Offset 5 stores the whole data byte as the selected voice's panning.
- R6: With direct mode clear, a write at offset 6 stores data bits 4:0 in the table entry at the write pointer. The pointer then advances by one and wraps from 31 to 0.
- R7: With direct mode set, a write at offset 6 loads data bits 4:0 into the direct sample. The table and the pointer do not change.
- R8: At offset 7, noise enable takes data bit 7 only when the latch is 4 or 5; for voices 0 to 3 it is written 0. The noise rate takes bits 4:0, except that 31 is stored as 30.
- R9: A write at offset 9 with bit 7 at 0 and bits 1:0 nonzero clears voice 1's enable, whatever the latch holds. Any other offset-9 value changes nothing.
- R10: While the latch holds 6 or 7, writes at offsets 2 to 7 change no state. Writes at offset 8, writes at offsets 10 to 15, and cycles with the write strobe low also change nothing.
- R11: After reset every stored value is 0: latch, master volumes, every voice field, every pointer and every table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register offset |
| wr_data | input | 8 | Write data |
| rd_voice | input | 3 | Voice shown on the read ports |
| rd_wave_idx | input | 5 | Table entry shown on rd_wave_smp |
| cur_voice | output | 3 | Voice-select latch |
| main_vol_l | output | 4 | Left master volume |
| main_vol_r | output | 4 | Right master volume |
| rd_freq | output | 12 | Pitch of the read voice |
| rd_level | output | 5 | Level of the read voice |
| rd_enable | output | 1 | Enable of the read voice |
| rd_direct | output | 1 | Direct-output mode of the read voice |
| rd_pan | output | 8 | Panning byte of the read voice |
| rd_noise_en | output | 1 | Noise enable of the read voice |
| rd_noise_rate | output | 5 | Noise rate of the read voice |
| rd_wave_ptr | output | 5 | Wave write pointer of the read voice |
| rd_direct_val | output | 5 | Direct sample of the read voice |
| rd_wave_smp | output | 8 | Selected table entry of the read voice, zero-extended |

## Verification
The assertions check, on every cycle, the behaviours that show at the global ports. These are the latch and master-volume loads, the voice-1 kill at offset 9, and the rule that ignored offsets and out-of-range latch values leave the enables and the global state unchanged.

Per-voice behaviour needs write sequences that only the bench scenarios produce. That covers the pitch merge, the pointer wrap after 32 samples, the split between table and direct sample, the pointer reset, and the restriction of noise to voices 4 and 5. After each scenario the bench sweeps every voice and every table entry against a model built from the requirements.

// File: rtl/snd_pkg.sv
package snd_pkg;
    localparam int SEL_W   = 3;
    localparam int FREQ_W  = 12;
    localparam int LEVEL_W = 5;
    localparam int SMP_W   = 5;
    localparam int RATE_W  = 5;

    localparam logic [3:0] OFF_SEL    = 4'd0;
    localparam logic [3:0] OFF_MVOL   = 4'd1;
    localparam logic [3:0] OFF_FLO    = 4'd2;
    localparam logic [3:0] OFF_FHI    = 4'd3;
    localparam logic [3:0] OFF_CTRL   = 4'd4;
    localparam logic [3:0] OFF_PAN    = 4'd5;
    localparam logic [3:0] OFF_WAVE   = 4'd6;
    localparam logic [3:0] OFF_NOISE  = 4'd7;
    localparam logic [3:0] OFF_MODR   = 4'd8;
    localparam logic [3:0] OFF_MODC   = 4'd9;

    typedef enum logic [3:0] {
        K_NONE, K_SEL, K_MVOL, K_FLO, K_FHI, K_CTRL,
        K_PAN, K_WAVE, K_NOISE, K_MODR, K_MODC
    } wr_kind_e;

    typedef struct packed {
        logic [FREQ_W-1:0]  freq;
        logic [LEVEL_W-1:0] level;
        logic               enable;
        logic               direct;
        logic [7:0]         pan;
        logic               noise_en;
        logic [RATE_W-1:0]  noise_rate;
        logic [SMP_W-1:0]   direct_val;
    } voice_st_t;
endpackage

// File: rtl/snd_wr_decode.sv
module snd_wr_decode
    import snd_pkg::*;
(
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic       ctl_b7,
    input  logic [1:0] ctl_lo,
    output wr_kind_e   kind,
    output logic       kill_v1
);
    always_comb begin
        kind = K_NONE;
        if (wr_en) begin
            unique case (wr_addr)
                OFF_SEL:   kind = K_SEL;
                OFF_MVOL:  kind = K_MVOL;
                OFF_FLO:   kind = K_FLO;
                OFF_FHI:   kind = K_FHI;
                OFF_CTRL:  kind = K_CTRL;
                OFF_PAN:   kind = K_PAN;
                OFF_WAVE:  kind = K_WAVE;
                OFF_NOISE: kind = K_NOISE;
                OFF_MODR:  kind = K_MODR;
                OFF_MODC:  kind = K_MODC;
                default:   kind = K_NONE;
            endcase
        end
    end

    assign kill_v1 = (kind == K_MODC) && !ctl_b7 && (ctl_lo != 2'b00);
endmodule

// File: rtl/snd_voice.sv
module snd_voice
    import snd_pkg::*;
#(
    parameter int WAVE_DEPTH = 32,
    localparam int PTR_W = $clog2(WAVE_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_kind_e         kind,
    input  logic [7:0]       data,
    input  logic             hit,
    input  logic             noise_ok,
    input  logic             kill,
    input  logic [PTR_W-1:0] rd_idx,
    output voice_st_t        st,
    output logic [PTR_W-1:0] ptr,
    output logic [SMP_W-1:0] rd_smp
);
    logic [SMP_W-1:0] table_q [WAVE_DEPTH];
    logic [PTR_W-1:0] ptr_next;

    assign ptr_next = (ptr == PTR_W'(WAVE_DEPTH - 1)) ? '0 : ptr + 1'b1;
    assign rd_smp   = table_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= '0;
            ptr <= '0;
            for (int i = 0; i < WAVE_DEPTH; i++) table_q[i] <= '0;
        end else begin
            if (hit) begin
                unique case (kind)
                    K_FLO:  st.freq[7:0] <= data;
                    K_FHI:  st.freq[FREQ_W-1:8] <= data[FREQ_W-9:0];
                    K_CTRL: begin
                        st.level  <= data[LEVEL_W-1:0];
                        st.enable <= data[7];
                        st.direct <= data[6];
                        if (!data[7] && data[6]) ptr <= '0;
                    end
                    K_PAN:  st.pan <= data;
                    K_WAVE: begin
                        if (!st.direct) begin
                            table_q[ptr] <= data[SMP_W-1:0];
                            ptr          <= ptr_next;
                        end else begin
                            st.direct_val <= data[SMP_W-1:0];
                        end
                    end
                    K_NOISE: begin
                        st.noise_en   <= data[7] & noise_ok;
                        st.noise_rate <= (data[RATE_W-1:0] == '1) ?
                                         {{(RATE_W-1){1'b1}}, 1'b0} : data[RATE_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (kill) st.enable <= 1'b0;
        end
    end
endmodule

// File: rtl/snd_regfront.sv
module snd_regfront
    import snd_pkg::*;
#(
    parameter int NUM_VOICES  = 6,
    parameter int NOISE_FIRST = 4,
    parameter int WAVE_DEPTH  = 32,
    localparam int PTR_W = $clog2(WAVE_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [SEL_W-1:0]   rd_voice,
    input  logic [PTR_W-1:0]   rd_wave_idx,
    output logic [SEL_W-1:0]   cur_voice,
    output logic [3:0]         main_vol_l,
    output logic [3:0]         main_vol_r,
    output logic [FREQ_W-1:0]  rd_freq,
    output logic [LEVEL_W-1:0] rd_level,
    output logic               rd_enable,
    output logic               rd_direct,
    output logic [7:0]         rd_pan,
    output logic               rd_noise_en,
    output logic [RATE_W-1:0]  rd_noise_rate,
    output logic [PTR_W-1:0]   rd_wave_ptr,
    output logic [SMP_W-1:0]   rd_direct_val,
    output logic [7:0]         rd_wave_smp
);
    wr_kind_e             kind;
    logic                 kill_v1;
    voice_st_t            vst  [NUM_VOICES];
    logic [PTR_W-1:0]     vptr [NUM_VOICES];
    logic [SMP_W-1:0]     vsmp [NUM_VOICES];
    logic [NUM_VOICES-1:0] en_vec;

    snd_wr_decode dec_i (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .ctl_b7  (wr_data[7]),
        .ctl_lo  (wr_data[1:0]),
        .kind    (kind),
        .kill_v1 (kill_v1)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_voice  <= '0;
            main_vol_l <= '0;
            main_vol_r <= '0;
        end else begin
            unique case (kind)
                K_SEL:  cur_voice <= wr_data[SEL_W-1:0];
                K_MVOL: begin
                    main_vol_l <= wr_data[7:4];
                    main_vol_r <= wr_data[3:0];
                end
                default: ;
            endcase
        end
    end

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        snd_voice #(.WAVE_DEPTH(WAVE_DEPTH)) voice_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .kind     (kind),
            .data     (wr_data),
            .hit      (cur_voice == SEL_W'(v)),
            .noise_ok (cur_voice >= SEL_W'(NOISE_FIRST)),
            .kill     ((v == 1) ? kill_v1 : 1'b0),
            .rd_idx   (rd_wave_idx),
            .st       (vst[v]),
            .ptr      (vptr[v]),
            .rd_smp   (vsmp[v])
        );
        assign en_vec[v] = vst[v].enable;
    end

    always_comb begin
        rd_freq       = '0;
        rd_level      = '0;
        rd_enable     = 1'b0;
        rd_direct     = 1'b0;
        rd_pan        = '0;
        rd_noise_en   = 1'b0;
        rd_noise_rate = '0;
        rd_wave_ptr   = '0;
        rd_direct_val = '0;
        rd_wave_smp   = '0;
        for (int v = 0; v < NUM_VOICES; v++) begin
            if (rd_voice == SEL_W'(v)) begin
                rd_freq       = vst[v].freq;
                rd_level      = vst[v].level;
                rd_enable     = vst[v].enable;
                rd_direct     = vst[v].direct;
                rd_pan        = vst[v].pan;
                rd_noise_en   = vst[v].noise_en;
                rd_noise_rate = vst[v].noise_rate;
                rd_wave_ptr   = vptr[v];
                rd_direct_val = vst[v].direct_val;
                rd_wave_smp   = 8'(vsmp[v]);
            end
        end
    end
endmodule

// File: rtl/snd_regfront_chk.sv
module snd_regfront_chk #(
    parameter int NUM_VOICES = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [3:0]            wr_addr,
    input logic [7:0]            wr_data,
    input logic [2:0]            cur_voice,
    input logic [3:0]            main_vol_l,
    input logic [3:0]            main_vol_r,
    input logic [NUM_VOICES-1:0] en_vec
);
    // R1
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd0) |=> (cur_voice == $past(wr_data[2:0])));

    // R2
    mvol_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd1) |=>
            (main_vol_l == $past(wr_data[7:4]) && main_vol_r == $past(wr_data[3:0])));

    // R9
    v1_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd9 && !wr_data[7] && wr_data[1:0] != 2'b00) |=> !en_vec[1]);

    // R10
    unused_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr == 4'd8 || wr_addr >= 4'd10) |=>
            ($stable(cur_voice) && $stable(main_vol_l) && $stable(main_vol_r) && $stable(en_vec)));

    // R10
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cur_voice >= 3'(NUM_VOICES) && wr_addr >= 4'd2 && wr_addr <= 4'd7)
            |=> $stable(en_vec));
endmodule

bind snd_regfront snd_regfront_chk #(.NUM_VOICES(NUM_VOICES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cur_voice  (cur_voice),
    .main_vol_l (main_vol_l),
    .main_vol_r (main_vol_r),
    .en_vec     (en_vec)
);

// File: tb/snd_regfront_tb.sv
`timescale 1ns/1ps
module snd_regfront_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_voice = '0;
    logic [4:0] rd_wave_idx = '0;
    logic [2:0] cur_voice;
    logic [3:0] main_vol_l, main_vol_r;
    logic [11:0] rd_freq;
    logic [4:0] rd_level, rd_noise_rate, rd_wave_ptr, rd_direct_val;
    logic       rd_enable, rd_direct, rd_noise_en;
    logic [7:0] rd_pan, rd_wave_smp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_sel, m_l, m_r;
    int m_freq[6], m_lvl[6], m_en[6], m_dir[6], m_pan[6];
    int m_nen[6], m_nrate[6], m_ptr[6], m_dval[6];
    int m_tab[6][32];

    always #2.5 clk = ~clk;

    snd_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_voice(rd_voice), .rd_wave_idx(rd_wave_idx), .cur_voice(cur_voice),
        .main_vol_l(main_vol_l), .main_vol_r(main_vol_r), .rd_freq(rd_freq),
        .rd_level(rd_level), .rd_enable(rd_enable), .rd_direct(rd_direct),
        .rd_pan(rd_pan), .rd_noise_en(rd_noise_en), .rd_noise_rate(rd_noise_rate),
        .rd_wave_ptr(rd_wave_ptr), .rd_direct_val(rd_direct_val), .rd_wave_smp(rd_wave_smp)
    );

    task automatic chk(input string tag, input string ctx, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) actual %0d expected %0d", tag, ctx, act, exp);
        end
    endtask

    task automatic mdl(input int a, input logic [7:0] d);
        int v;
        if (a == 0) m_sel = int'(d[2:0]);
        else if (a == 1) begin m_l = int'(d[7:4]); m_r = int'(d[3:0]); end
        else if (a == 9) begin
            if (!d[7] && d[1:0] != 2'b00) m_en[1] = 0;
        end else if (a >= 2 && a <= 7 && m_sel < 6) begin
            v = m_sel;
            case (a)
                2: m_freq[v] = (m_freq[v] & 'hF00) | int'(d);
                3: m_freq[v] = (m_freq[v] & 'h0FF) | (int'(d[3:0]) << 8);
                4: begin
                    m_lvl[v] = int'(d[4:0]); m_en[v] = int'(d[7]); m_dir[v] = int'(d[6]);
                    if (!d[7] && d[6]) m_ptr[v] = 0;
                end
                5: m_pan[v] = int'(d);
                6: begin
                    if (m_dir[v] == 0) begin
                        m_tab[v][m_ptr[v]] = int'(d[4:0]);
                        m_ptr[v] = (m_ptr[v] + 1) % 32;
                    end else m_dval[v] = int'(d[4:0]);
                end
                default: begin
                    m_nen[v]   = (d[7] && m_sel >= 4) ? 1 : 0;
                    m_nrate[v] = (d[4:0] == 5'h1F) ? 30 : int'(d[4:0]);
                end
            endcase
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mdl(a, d);
    endtask

    task automatic check_all(input string ctx);
        chk("R1", ctx, int'(cur_voice), m_sel);
        chk("R2", ctx, int'(main_vol_l), m_l);
        chk("R2", ctx, int'(main_vol_r), m_r);
        for (int v = 0; v < 6; v++) begin
            rd_voice = 3'(v); rd_wave_idx = '0;
            #0.1;
            chk("R3", ctx, int'(rd_freq), m_freq[v]);
            chk("R4", ctx, int'(rd_level), m_lvl[v]);
            chk("R4", ctx, int'(rd_enable), m_en[v]);
            chk("R4", ctx, int'(rd_direct), m_dir[v]);
            chk("R5", ctx, int'(rd_pan), m_pan[v]);
            chk("R8", ctx, int'(rd_noise_en), m_nen[v]);
            chk("R8", ctx, int'(rd_noise_rate), m_nrate[v]);
            chk("R6", ctx, int'(rd_wave_ptr), m_ptr[v]);
            chk("R7", ctx, int'(rd_direct_val), m_dval[v]);
            for (int i = 0; i < 32; i++) begin
                rd_wave_idx = 5'(i);
                #0.1;
                chk("R6", ctx, int'(rd_wave_smp), m_tab[v][i]);
            end
        end
    endtask

    initial begin
        m_sel = 0; m_l = 0; m_r = 0;
        for (int v = 0; v < 6; v++) begin
            m_freq[v] = 0; m_lvl[v] = 0; m_en[v] = 0; m_dir[v] = 0; m_pan[v] = 0;
            m_nen[v] = 0; m_nrate[v] = 0; m_ptr[v] = 0; m_dval[v] = 0;
            for (int i = 0; i < 32; i++) m_tab[v][i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11 reset");

        for (int s = 0; s < 8; s++) begin
            wr(0, {5'b10110, 3'(s)});
            chk("R1", "latch sweep", int'(cur_voice), s);
        end
        for (int d = 0; d < 256; d += 17) begin
            wr(1, 8'(d));
            chk("R2", "vol sweep", int'(main_vol_l), d >> 4);
            chk("R2", "vol sweep", int'(main_vol_r), d & 15);
        end

        for (int v = 0; v < 6; v++) begin
            wr(0, 8'(v));
            wr(2, 8'('h5A ^ v));
            wr(3, 8'('hFC ^ v));
            wr(5, 8'('h30 + v));
            wr(4, 8'('h80 | (v * 3)));
            for (int i = 0; i < 35; i++) wr(6, 8'(i * 7 + v * 11 + 224));
            wr(7, 8'h9F);
        end
        check_all("R3 R4 R5 R6 R8 per-voice fill");

        wr(0, 8'd2); wr(4, 8'hC5); wr(6, 8'h13); wr(6, 8'hEE);
        check_all("R7 direct sample");
        wr(4, 8'h40);
        check_all("R4 pointer reset");
        wr(4, 8'h00); wr(6, 8'h09);
        check_all("R6 table after reset");

        wr(0, 8'd3); wr(7, 8'h85);
        wr(0, 8'd5); wr(7, 8'h1E);
        wr(0, 8'd4); wr(7, 8'h1F);
        check_all("R8 noise rules");

        wr(9, 8'h81); check_all("R9 bit7 set");
        wr(9, 8'h7C); check_all("R9 low bits zero");
        wr(9, 8'h02); check_all("R9 kill");
        wr(0, 8'd1); wr(4, 8'h9F); wr(0, 8'd4); wr(9, 8'h01);
        check_all("R9 kill again");

        for (int s = 6; s < 8; s++) begin
            wr(0, 8'(s));
            for (int a = 2; a < 8; a++) wr(a, 8'hFF);
            wr(6, 8'h55);
        end
        wr(8, 8'hFF);
        for (int a = 10; a < 16; a++) wr(a, 8'hA7);
        @(negedge clk);
        wr_addr = 4'd1; wr_data = 8'h00; wr_en = 1'b0;
        @(negedge clk);
        wr_addr = 4'd0; wr_data = 8'h03;
        @(negedge clk);
        check_all("R10 ignored writes");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule